// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing half of a byte-addressed serial memory of 32K locations. It watches an oversampled two-wire bus (clock and data lines brought onto the system clock), recognises start and stop conditions, and answers a control byte that carries a fixed device code, a three-bit strap match and a direction bit. Writes deliver a two-byte word address and then a stream of data bytes. Each data byte is handed to a page buffer as an address/data pulse, and a commit pulse follows a clean stop. Reads return bytes from a synchronous RAM port with one cycle of latency, shifted out through an open-drain data enable.

A single address pointer is shared by every command. Loading it in a write and then issuing a repeated start gives a random read. Reading without loading it continues from where the last access left off. Acknowledging each read byte keeps the stream going, and the pointer wraps from the last location back to zero. While the external write-cycle controller signals busy, the engine stays silent, so a master can poll for the end of the write cycle.

Top module: `i2c_mem_slave`

## Requirements
- R1: A falling data line while the clock is high starts a transaction. A rising data line while the clock is high stops it. Either condition arriving after the second clock pulse of a byte abandons that byte: a stop returns to idle with no commit, and a start waits for a fresh control byte.
- R2: The first byte after a start is compared MSB first. Bits 7..4 must be 1010, bits 3..1 must equal strap_i[2:0], and bit 0 selects read (1) or write (0). A match is acknowledged by holding sda_oe high through the ninth clock high phase.
- R3: When the control byte does not match, sda_oe stays low and every later byte is ignored until the next start.
- R4: While busy_i is high, no byte is acknowledged, including a matching control byte.
- R5: On a write, the next two bytes are the word address, high byte first. Bit 7 of the high byte is ignored. Both bytes are acknowledged.
- R6: Each further write byte is acknowledged and produces one wr_valid pulse carrying the current pointer and the byte, after which the pointer advances by one. A stop at a byte boundary after at least one data byte produces one wr_commit pulse. No other event produces a wr_commit pulse.
- R7: A read with no address phase returns the byte at the location after the last one read or written.
- R8: A repeated start after the address bytes keeps the loaded pointer, so the following read returns that location.
- R9: After a read byte, a master acknowledge makes the engine send the next location. A master non-acknowledge makes it release the data line.
- R10: The pointer wraps from 7FFF to 0000 when it steps past the top location.
- R11: Read data leaves MSB first, and sda_oe changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Device select straps |
| busy_i | input | 1 | Write cycle in progress |
| mem_rd_en | output | 1 | RAM read strobe |
| mem_addr | output | 15 | RAM read address |
| mem_rd_data | input | 8 | RAM read data, valid one cycle after the strobe |
| wr_valid | output | 1 | Write byte pulse to the page buffer |
| wr_addr | output | 15 | Address of the write byte |
| wr_data | output | 8 | Write byte |
| wr_commit | output | 1 | End-of-write pulse after a clean stop |

## Verification
A corrupted pointer shows up as a wrong byte on the very next read, at most nine bus clocks after the fault. A slipped bit counter moves or drops the acknowledge, which is seen in the ninth high phase of the byte it affects. A stale state shows up as a missing acknowledge, a missing commit pulse or a spurious write pulse by the end of the next byte. The bench therefore sweeps every control byte value and walks the pointer across the top of memory, so that each kind of fault appears within one transaction.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;

    localparam int          BYTE_W   = 8;
    localparam logic [3:0]  DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_WDATA,
        ST_RDATA
    } eng_state_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_ev_t;

    function automatic logic ctrl_hit(input logic [7:0] b, input logic [2:0] strap);
        return (b[7:4] == DEV_CODE) && (b[3:1] == strap);
    endfunction

    function automatic logic is_rx_state(input eng_state_e s);
        return (s == ST_CTRL) || (s == ST_ADDR_HI) || (s == ST_ADDR_LO) || (s == ST_WDATA);
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_mem_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    output line_ev_t ev
);
    // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-1:0], din};
    end

    always_comb begin
        ev.level = sh[STAGES-1];
        ev.rise  = sh[STAGES-1] & ~sh[STAGES];
        ev.fall  = ~sh[STAGES-1] & sh[STAGES];
    end
endmodule

// File: rtl/i2c_addr_ptr.sv
module i2c_addr_ptr #(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_hi,
    input  logic              load_lo,
    input  logic              step,
    input  logic [7:0]        byte_in,
    output logic [ADDR_W-1:0] ptr
);
    localparam int HI_W = ADDR_W - 8;
    localparam logic [ADDR_W-1:0] ONE = 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load_hi) begin
            ptr[ADDR_W-1:8] <= byte_in[HI_W-1:0];
        end else if (load_lo) begin
            ptr[7:0] <= byte_in;
        end else if (step) begin
            ptr <= ptr + ONE;
        end
    end

    // R10
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load_hi && !load_lo && ptr == '1) |=> (ptr == '0));

    // R5
    hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (rst)
        load_hi |=> (ptr[7:0] == $past(ptr[7:0])));
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
    import i2c_mem_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        strap_i,
    input  logic              busy_i,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              wr_commit
);
    localparam int         CNT_W   = 4;
    localparam logic [CNT_W-1:0] CNT_ACK = 4'd8;
    localparam logic [CNT_W-1:0] CNT_END = 4'd9;
    localparam logic [CNT_W-1:0] CNT_ONE = 4'd1;

    // ---- line synchronisers (index 0: clock line, 1: data line)
    line_ev_t   lines [2];
    logic [1:0] raw;
    assign raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw[g]),
            .ev  (lines[g])
        );
    end

    line_ev_t scl_ev, sda_ev;
    assign scl_ev = lines[0];
    assign sda_ev = lines[1];

    logic bus_start, bus_stop;
    assign bus_start = sda_ev.fall & scl_ev.level;
    assign bus_stop  = sda_ev.rise & scl_ev.level;

    // ---- engine state
    eng_state_e       state;
    logic [CNT_W-1:0] bitcnt;
    logic [7:0]       rx_sh;
    logic [7:0]       tx_sh;
    logic             is_read;
    logic             mack;
    logic             got_data;
    logic             rd_pend;
    logic [ADDR_W-1:0] ptr;

    logic ack_begin, frame_end, ctrl_ok, rd_req;
    logic ld_hi, ld_lo, ptr_step;

    assign ack_begin = scl_ev.fall && (bitcnt == CNT_ACK) && (state != ST_IDLE)
                       && !bus_start && !bus_stop;
    assign frame_end = scl_ev.fall && (bitcnt == CNT_END) && (state != ST_IDLE)
                       && !bus_start && !bus_stop;
    assign ctrl_ok   = ctrl_hit(rx_sh, strap_i) && !busy_i;

    assign ld_hi    = ack_begin && (state == ST_ADDR_HI) && !busy_i;
    assign ld_lo    = ack_begin && (state == ST_ADDR_LO) && !busy_i;
    assign ptr_step = ack_begin && (((state == ST_WDATA) && !busy_i) || (state == ST_RDATA));

    assign rd_req = (ack_begin && (state == ST_CTRL) && ctrl_ok && rx_sh[0])
                 || ((state == ST_RDATA) && scl_ev.rise && (bitcnt == CNT_ACK)
                     && !bus_start && !bus_stop);

    assign mem_rd_en = rd_req;
    assign mem_addr  = ptr;

    i2c_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .load_hi (ld_hi),
        .load_lo (ld_lo),
        .step    (ptr_step),
        .byte_in (rx_sh),
        .ptr     (ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            is_read   <= 1'b0;
            mack      <= 1'b0;
            got_data  <= 1'b0;
            rd_pend   <= 1'b0;
            sda_oe    <= 1'b0;
            wr_valid  <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
        end else begin
            wr_valid  <= 1'b0;
            wr_commit <= 1'b0;
            rd_pend   <= rd_req;
            if (rd_pend) tx_sh <= mem_rd_data;

            if (bus_stop) begin
                if (state == ST_WDATA && got_data && bitcnt <= CNT_ONE)
                    wr_commit <= 1'b1;
                state  <= ST_IDLE;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (bus_start) begin
                state    <= ST_CTRL;
                bitcnt   <= '0;
                sda_oe   <= 1'b0;
                got_data <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_ev.rise && bitcnt < CNT_END) begin
                    bitcnt <= bitcnt + CNT_ONE;
                    if (bitcnt < CNT_ACK) rx_sh <= {rx_sh[6:0], sda_ev.level};
                    if (bitcnt == CNT_ACK) mack <= ~sda_ev.level;
                end

                if (ack_begin) begin
                    case (state)
                        ST_CTRL: begin
                            if (ctrl_ok) begin
                                sda_oe  <= 1'b1;
                                is_read <= rx_sh[0];
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_IDLE;
                            end
                        end
                        ST_ADDR_HI, ST_ADDR_LO: begin
                            if (!busy_i) sda_oe <= 1'b1;
                            else         state  <= ST_IDLE;
                        end
                        ST_WDATA: begin
                            if (!busy_i) begin
                                sda_oe   <= 1'b1;
                                wr_valid <= 1'b1;
                                wr_addr  <= ptr;
                                wr_data  <= rx_sh;
                                got_data <= 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                        default: sda_oe <= 1'b0;
                    endcase
                end else if (frame_end) begin
                    bitcnt <= '0;
                    case (state)
                        ST_CTRL: begin
                            state  <= is_read ? ST_RDATA : ST_ADDR_HI;
                            sda_oe <= is_read ? ~tx_sh[7] : 1'b0;
                        end
                        ST_ADDR_HI: begin
                            state  <= ST_ADDR_LO;
                            sda_oe <= 1'b0;
                        end
                        ST_ADDR_LO: begin
                            state  <= ST_WDATA;
                            sda_oe <= 1'b0;
                        end
                        ST_WDATA: sda_oe <= 1'b0;
                        ST_RDATA: begin
                            if (mack) begin
                                sda_oe <= ~tx_sh[7];
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_IDLE;
                            end
                        end
                        default: sda_oe <= 1'b0;
                    endcase
                end else if (scl_ev.fall && state == ST_RDATA
                             && bitcnt >= CNT_ONE && bitcnt < CNT_ACK) begin
                    sda_oe <= ~tx_sh[~bitcnt[2:0]];
                end
            end
        end
    end

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_ev.level);

    // R3
    ctrl_mismatch_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_begin && state == ST_CTRL && rx_sh[7:4] != DEV_CODE)
        |=> (!sda_oe && state == ST_IDLE));

    // R4
    busy_noack_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_begin && busy_i && is_rx_state(state)) |=> !sda_oe);

    // R6
    wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |=> !wr_valid);
endmodule

// File: tb/test_i2c_mem_slave.sv
`timescale 1ns/1ps
module test_i2c_mem_slave;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        msda = 1'b1;
    logic        sda_oe;
    logic [2:0]  strap = 3'b101;
    logic        busy = 1'b0;
    logic        mem_rd_en;
    logic [14:0] mem_addr;
    logic [7:0]  mem_rd_data = 8'h00;
    logic        wr_valid, wr_commit;
    logic [14:0] wr_addr;
    logic [7:0]  wr_data;
    logic        bus_sda;

    always #2 clk = ~clk;
    assign bus_sda = msda & ~sda_oe;

    i2c_mem_slave i_i2c_mem_slave (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(bus_sda), .sda_oe(sda_oe),
        .strap_i(strap), .busy_i(busy), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_data(mem_rd_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_commit(wr_commit)
    );

    function automatic logic [7:0] pat(input logic [14:0] a);
        return a[7:0] ^ {a[14:8], 1'b0} ^ 8'h3C;
    endfunction

    always @(posedge clk) if (mem_rd_en) mem_rd_data <= pat(mem_addr);

    int total = 0, passed = 0, viol = 0, wcount = 0, ccount = 0;
    logic [14:0] wa [8];
    logic [7:0]  wd [8];
    logic prev_oe = 1'b0;
    bit   done = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (sda_oe != prev_oe && scl) viol++;
            if (wr_valid) begin
                if (wcount < 8) begin wa[wcount] = wr_addr; wd[wcount] = wr_data; end
                wcount++;
            end
            if (wr_commit) ccount++;
        end
        prev_oe = sda_oe;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (ok) passed++;
        else $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        msda = 1'b1; tick(HALF);
        scl = 1'b1;  tick(HALF);
        msda = 1'b0; tick(HALF);
        scl = 1'b0;  tick(HALF);
    endtask

    task automatic bus_stop();
        msda = 1'b0; tick(HALF);
        scl = 1'b1;  tick(HALF);
        msda = 1'b1; tick(HALF);
    endtask

    task automatic send_bit(input logic b);
        msda = b;   tick(HALF);
        scl = 1'b1; tick(HALF);
        scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        msda = 1'b1; tick(HALF);
        scl = 1'b1;  tick(HALF / 2);
        acked = (bus_sda == 1'b0);
        tick(HALF - HALF / 2);
        scl = 1'b0;
    endtask

    task automatic read_byte(input bit master_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            msda = 1'b1; tick(HALF);
            scl = 1'b1;  tick(HALF / 2);
            b[i] = bus_sda;
            tick(HALF - HALF / 2);
            scl = 1'b0;
        end
        msda = master_ack ? 1'b0 : 1'b1; tick(HALF);
        scl = 1'b1; tick(HALF);
        scl = 1'b0;
        tick(2);
        msda = 1'b1;
    endtask

    initial begin
        bit ak;
        logic [7:0] d;
        int w0, c0;
        tick(5);
        rst = 1'b0;
        tick(3);
        // R1 reset state: line released
        chk(sda_oe == 1'b0, "R1 reset", sda_oe, 0);

        // R2 sweep of every control byte value against strap 101
        for (int v = 0; v < 256; v++) begin
            bit exp_ack;
            exp_ack = (v[7:1] == 7'b1010101);
            bus_start();
            send_byte(8'(v), ak);
            chk(ak == exp_ack, "R2 control match", ak, exp_ack);
            if (ak && v[0]) read_byte(1'b0, d);
            bus_stop();
        end

        // R3 mismatch then ignore the rest until the next start
        bus_start();
        send_byte(8'h50, ak);
        chk(!ak, "R3 mismatch", ak, 0);
        send_byte(8'hAA, ak);
        chk(!ak, "R3 ignored after mismatch", ak, 0);
        bus_stop();

        // R2 another strap value
        strap = 3'b010;
        bus_start(); send_byte(8'hA4, ak); bus_stop();
        chk(ak, "R2 strap 010", ak, 1);
        bus_start(); send_byte(8'hAA, ak); bus_stop();
        chk(!ak, "R2 strap mismatch", ak, 0);
        strap = 3'b101;

        // R5 / R6 page write, high address bit 7 ignored
        w0 = wcount; c0 = ccount;
        bus_start();
        send_byte(8'hAA, ak); chk(ak, "R5 ctrl ack", ak, 1);
        send_byte(8'h92, ak); chk(ak, "R5 addr hi ack", ak, 1);
        send_byte(8'h34, ak); chk(ak, "R5 addr lo ack", ak, 1);
        send_byte(8'hC1, ak); chk(ak, "R6 data ack", ak, 1);
        send_byte(8'h5E, ak); chk(ak, "R6 data ack", ak, 1);
        send_byte(8'h07, ak); chk(ak, "R6 data ack", ak, 1);
        bus_stop();
        tick(4);
        chk(wcount - w0 == 3, "R6 write count", wcount - w0, 3);
        chk(ccount - c0 == 1, "R6 commit count", ccount - c0, 1);
        chk(wa[w0] == 15'h1234 && wd[w0] == 8'hC1, "R5 first write", wa[w0], 15'h1234);
        chk(wa[w0+1] == 15'h1235 && wd[w0+1] == 8'h5E, "R6 second write", wa[w0+1], 15'h1235);
        chk(wa[w0+2] == 15'h1236 && wd[w0+2] == 8'h07, "R6 third write", wa[w0+2], 15'h1236);

        // R7 current-address read after the write
        bus_start(); send_byte(8'hAB, ak); read_byte(1'b0, d); bus_stop();
        chk(d == pat(15'h1237), "R7 current read", d, pat(15'h1237));

        // R8 / R9 / R10 random read across the top of memory
        c0 = ccount;
        bus_start();
        send_byte(8'hAA, ak);
        send_byte(8'h7F, ak);
        send_byte(8'hFE, ak);
        bus_start();
        send_byte(8'hAB, ak); chk(ak, "R8 read ctrl ack", ak, 1);
        read_byte(1'b1, d); chk(d == pat(15'h7FFE), "R8 random read", d, pat(15'h7FFE));
        read_byte(1'b1, d); chk(d == pat(15'h7FFF), "R9 sequential read", d, pat(15'h7FFF));
        read_byte(1'b0, d); chk(d == pat(15'h0000), "R10 rollover", d, pat(15'h0000));
        tick(HALF);
        chk(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
        bus_stop();
        tick(4);
        chk(ccount == c0, "R6 no commit without data", ccount, c0);
        bus_start(); send_byte(8'hAB, ak); read_byte(1'b0, d); bus_stop();
        chk(d == pat(15'h0001), "R7 read after rollover", d, pat(15'h0001));

        // R4 busy suppresses acknowledges
        w0 = wcount;
        busy = 1'b1;
        bus_start(); send_byte(8'hAA, ak); bus_stop();
        chk(!ak, "R4 busy ctrl", ak, 0);
        busy = 1'b0;
        bus_start(); send_byte(8'hAA, ak);
        busy = 1'b1;
        send_byte(8'h00, ak);
        chk(!ak, "R4 busy address byte", ak, 0);
        busy = 1'b0;
        bus_stop();
        chk(wcount == w0, "R4 no write while busy", wcount, w0);

        // R1 stop in the middle of a byte abandons it without commit
        c0 = ccount;
        bus_start();
        send_byte(8'hAA, ak); send_byte(8'h01, ak); send_byte(8'h00, ak);
        send_byte(8'h99, ak);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        tick(4);
        chk(wcount - w0 == 1 && wa[w0] == 15'h0100, "R1 byte before abort", wcount - w0, 1);
        chk(ccount == c0, "R1 no commit on mid-byte stop", ccount, c0);

        // R1 start in the middle of a byte waits for a control byte
        bus_start();
        send_byte(8'hAA, ak);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        bus_start();
        send_byte(8'hAB, ak); chk(ak, "R1 ctrl after mid-byte start", ak, 1);
        read_byte(1'b0, d); bus_stop();
        chk(d == pat(15'h0101), "R1 pointer after abort", d, pat(15'h0101));

        // R11 slave-driven line never moved while the clock was high
        chk(viol == 0, "R11 data change while clock high", viol, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", passed, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", passed, total);
            $finish;
        end
    end
endmodule